// File: doc/BRIEF.md
# Triggered Event Frame Builder

This block turns one accepted trigger into a single framed event record for 48 input channels. The channels are handled as twelve 4-channel groups. Every four groups form one 16-channel section. An upstream buffer streams the hit words of the groups one after another, in group order. After the last hit of a group it sends one end-of-group marker beat. The builder wraps this stream in framing words: two event headers, a group header ahead of each group's hits, and an ender after each section. The result goes out as a 16-bit word stream with valid/ready flow control.

The builder keeps a per-event count of stored hits. Once the event-wide hit budget is used up, it still accepts further hit beats but drops them. All remaining group headers and enders are emitted as usual, so the record keeps its full shape. The ender of the section in which the first hit was dropped carries a truncation flag, and so does every later ender of that event. A downstream reader therefore always finds a complete skeleton and can tell from it that the event is bad.

Word kinds are told apart by their top bits. Bits 15:14 equal to 01 mark an event number header, 10 a group header, and 11 a hit. Bits 15:13 equal to 001 mark the second header, and 000 an ender.

Top module: `eb_builder`

## Requirements
- R1: A synchronous active-low reset, applied at any time, returns the block to idle. In idle, trig_ready=1, out_valid=0 and hit_ready=0.
- R2: The first word of each event is {2'b01, event number[13:0]}. The event number is captured when the trigger is accepted, and the full range up to 16383 is carried unchanged.
- R3: The second word is {3'b001, BOARD_ID[4:0], 8'h00}.
- R4: For each group g (0 to 11, in order), a group header {2'b10, 9'b0, GRP_BASE+g as 5 bits} is emitted first. It is followed by the group's hit words {2'b11, hit_word[13:0]} in arrival order. hit_word holds the channel number in bits 13:10, the edge flags in bits 9:8 and the timestamp in bits 7:0.
- R5: After the hits of groups 3, 7 and 11, one ender {3'b000, trunc, 12'h000} is emitted. The third ender is the last word of the event.
- R6: At most MAX_HITS (default 123) hit words are stored per event. Framing words do not count toward this limit, and the count restarts at every accepted trigger.
- R7: A hit beat that arrives with the budget exhausted is consumed (hit_ready=1) and dropped. The ender of that section and all later enders of the same event carry trunc=1. An event with exactly MAX_HITS hits has trunc=0 in all enders.
- R8: trig_ready is 1 only while idle, so a trigger is accepted only after the last ender has been taken. While idle, no word is offered.
- R9: While out_ready is low, an offered framing word stays valid and unchanged.
- R10: An end-of-group marker beat (hit_end=1) is consumed without producing an output word. No hit beat is accepted outside the hit phase of a group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trig_valid | input | 1 | Trigger request |
| trig_ready | output | 1 | Builder idle, trigger can be taken |
| trig_evnum | input | 14 | Event number for the trigger |
| hit_valid | input | 1 | Hit stream beat valid |
| hit_ready | output | 1 | Hit stream beat accepted |
| hit_end | input | 1 | Beat is the end-of-group marker, not a hit |
| hit_word | input | 14 | Channel, edge flags and timestamp of a hit |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts output word |
| out_data | output | 16 | Output event word |

## Verification
The hardest situation to reach is a budget overrun that starts in the last section. It takes more than 120 hits spread over the groups, so that the first and second enders stay clean and only the third one is flagged. The bench builds such events from per-group hit counts in its table, including one with exactly 123 and one with 124 hits, while a periodic stall on out_ready runs alongside. A further event after the overrun shows that the hit count was cleared. A reset applied while the builder waits in a group's hit phase shows that it recovers to idle.

// File: rtl/eb_pkg.sv
// Shared types and word formatting for the event frame builder.
// Assumes a 16-bit output word with the kind encoded in the top bits.
package eb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR0,
        ST_HDR1,
        ST_GHDR,
        ST_HITS,
        ST_ENDER
    } eb_state_t;

    // First event header: kind 01 and the event number
    function automatic logic [15:0] mk_hdr0(input logic [13:0] ev);
        return {2'b01, ev};
    endfunction

    // Second event header: kind 001 and the board identifier
    function automatic logic [15:0] mk_hdr1(input logic [4:0] bid);
        return {3'b001, bid, 8'h00};
    endfunction

    // Group header: kind 10 and the 5-bit board/group id
    function automatic logic [15:0] mk_ghdr(input logic [4:0] id);
        return {2'b10, 9'h000, id};
    endfunction

    // Hit word: kind 11 and the upstream payload
    function automatic logic [15:0] mk_hit(input logic [13:0] w);
        return {2'b11, w};
    endfunction

    // Ender: kind 000 (same as an empty word) plus the truncation flag
    function automatic logic [15:0] mk_ender(input logic tr);
        return {3'b000, tr, 12'h000};
    endfunction

endpackage

// File: rtl/eb_budget.sv
// Per-event hit budget tracker.
// Counts stored hits, reports whether room is left, and keeps a sticky
// truncation flag once a hit has been dropped. Cleared on each new event.
module eb_budget #(
    parameter int MAX_HITS = 123
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic hit_take,
    output logic room,
    output logic trunc
);
    localparam int CW = $clog2(MAX_HITS + 1);

    logic [CW-1:0] count;

    assign room = (count < CW'(MAX_HITS));

    // Count stored hits and latch truncation on the first dropped hit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            trunc <= 1'b0;
        end else if (clear) begin
            count <= '0;
            trunc <= 1'b0;
        end else if (hit_take) begin
            if (room) count <= count + 1'b1;
            else      trunc <= 1'b1;
        end
    end

endmodule

// File: rtl/eb_sequencer.sv
// Framing sequencer for one event.
// Steps through headers, group headers, hit phases and section enders.
// Assumes groups arrive in order, each closed by one end marker beat.
module eb_sequencer
    import eb_pkg::*;
#(
    parameter int N_SECT       = 3,
    parameter int GRP_PER_SECT = 4,
    parameter int GW           = $clog2(N_SECT * GRP_PER_SECT + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trig_fire,
    input  logic            word_done,
    input  logic            grp_end,
    output eb_state_t       state,
    output logic [GW-1:0]   grp_idx
);
    localparam int NGRP = N_SECT * GRP_PER_SECT;
    localparam int SW   = $clog2(GRP_PER_SECT + 1);

    logic [SW-1:0] sect_pos;

    // Advance the framing state on each completed step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            grp_idx  <= '0;
            sect_pos <= '0;
        end else begin
            case (state)
                ST_IDLE:  if (trig_fire) state <= ST_HDR0;
                ST_HDR0:  if (word_done) state <= ST_HDR1;
                ST_HDR1: if (word_done) begin
                    state    <= ST_GHDR;
                    grp_idx  <= '0;
                    sect_pos <= '0;
                end
                ST_GHDR:  if (word_done) state <= ST_HITS;
                ST_HITS: if (grp_end) begin
                    grp_idx <= grp_idx + 1'b1;
                    if (sect_pos == SW'(GRP_PER_SECT - 1)) begin
                        sect_pos <= '0;
                        state    <= ST_ENDER;
                    end else begin
                        sect_pos <= sect_pos + 1'b1;
                        state    <= ST_GHDR;
                    end
                end
                ST_ENDER: if (word_done) begin
                    if (grp_idx == GW'(NGRP)) state <= ST_IDLE;
                    else                      state <= ST_GHDR;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/eb_builder.sv
// Event frame builder top.
// Accepts a trigger, frames the incoming grouped hit stream into a
// 16-bit word stream, and truncates hits beyond the budget while keeping
// every header and ender. Output and hit input use valid/ready.
module eb_builder
    import eb_pkg::*;
#(
    parameter int N_SECT       = 3,
    parameter int GRP_PER_SECT = 4,
    parameter int MAX_HITS     = 123,
    parameter int BOARD_ID     = 5,
    parameter int GRP_BASE     = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        trig_valid,
    output logic        trig_ready,
    input  logic [13:0] trig_evnum,
    input  logic        hit_valid,
    output logic        hit_ready,
    input  logic        hit_end,
    input  logic [13:0] hit_word,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [15:0] out_data
);
    localparam int NGRP = N_SECT * GRP_PER_SECT;
    localparam int GW   = $clog2(NGRP + 1);

    eb_state_t      state;
    logic [GW-1:0]  grp_idx;
    logic [13:0]    ev_q;
    logic           room;
    logic           trunc;
    logic           trig_fire;
    logic           word_done;
    logic           grp_end;
    logic           hit_take;
    logic           in_hits;

    assign trig_ready = (state == ST_IDLE);
    assign trig_fire  = trig_valid && trig_ready;
    assign in_hits    = (state == ST_HITS);
    assign word_done  = out_valid && out_ready;
    assign grp_end    = in_hits && hit_valid && hit_end;
    assign hit_take   = in_hits && hit_valid && !hit_end && hit_ready;

    // Capture the event number when a trigger is accepted
    always_ff @(posedge clk) begin
        if (!rst_n)         ev_q <= '0;
        else if (trig_fire) ev_q <= trig_evnum;
    end

    // Pick the output word and the hit stream ready for the current step
    always_comb begin
        out_valid = 1'b0;
        out_data  = 16'h0000;
        hit_ready = 1'b0;
        case (state)
            ST_HDR0: begin
                out_valid = 1'b1;
                out_data  = mk_hdr0(ev_q);
            end
            ST_HDR1: begin
                out_valid = 1'b1;
                out_data  = mk_hdr1(5'(BOARD_ID));
            end
            ST_GHDR: begin
                out_valid = 1'b1;
                out_data  = mk_ghdr(5'(GRP_BASE) + 5'(grp_idx));
            end
            ST_HITS: begin
                out_valid = hit_valid && !hit_end && room;
                out_data  = mk_hit(hit_word);
                hit_ready = (hit_end || !room) ? 1'b1 : out_ready;
            end
            ST_ENDER: begin
                out_valid = 1'b1;
                out_data  = mk_ender(trunc);
            end
            default: ;
        endcase
    end

    eb_sequencer #(
        .N_SECT       (N_SECT),
        .GRP_PER_SECT (GRP_PER_SECT),
        .GW           (GW)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_fire (trig_fire),
        .word_done (word_done),
        .grp_end   (grp_end),
        .state     (state),
        .grp_idx   (grp_idx)
    );

    eb_budget #(
        .MAX_HITS (MAX_HITS)
    ) u_budget (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (trig_fire),
        .hit_take (hit_take),
        .room     (room),
        .trunc    (trunc)
    );

endmodule

// File: rtl/eb_builder_chk.sv
// Protocol checker for the event frame builder, bound to the top.
// Observes ports only; keeps its own per-event hit count and ender flag.
module eb_builder_chk #(
    parameter int MAX_HITS = 123
) (
    input logic        clk,
    input logic        rst_n,
    input logic        trig_valid,
    input logic        trig_ready,
    input logic        hit_valid,
    input logic        hit_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [15:0] out_data
);
    logic [8:0] hit_cnt;
    logic       seen_tr;
    logic       xfer;

    assign xfer = out_valid && out_ready;

    // Track hit words and flagged enders seen in the current event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_cnt <= '0;
            seen_tr <= 1'b0;
        end else if (trig_valid && trig_ready) begin
            hit_cnt <= '0;
            seen_tr <= 1'b0;
        end else if (xfer) begin
            if (out_data[15:14] == 2'b11) hit_cnt <= hit_cnt + 1'b1;
            if (out_data[15:13] == 3'b000 && out_data[12]) seen_tr <= 1'b1;
        end
    end

    p_rst_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (trig_ready && !out_valid && !hit_ready));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trig_ready |-> (!out_valid && !hit_ready));

    p_hold_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && out_data[15:14] != 2'b11)
        |=> (out_valid && $stable(out_data)));

    p_budget_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit_cnt <= 9'(MAX_HITS));

    p_sticky_trunc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && out_data[15:13] == 3'b000 && seen_tr) |-> out_data[12]);

    p_hit_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && hit_ready) |-> !trig_ready);

endmodule

bind eb_builder eb_builder_chk #(.MAX_HITS(MAX_HITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_valid (trig_valid),
    .trig_ready (trig_ready),
    .hit_valid  (hit_valid),
    .hit_ready  (hit_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data)
);

// File: tb/eb_builder_tb.sv
`timescale 1ns/1ps
// Bench for the event frame builder: table-driven events, then directed
// reset and idle checks. The expected word stream is built from the rules.
module eb_builder_tb;
    localparam int MAXH  = 123;
    localparam int BID   = 5;
    localparam int NVEC  = 6;

    // {event number[13:0], backpressure, per-group hit counts (4 bits each)}
    localparam logic [62:0] VEC [NVEC] = '{
        {14'd1,     1'b0, 48'h000000000000},
        {14'd2,     1'b1, 48'hCBA987654321},
        {14'h3FFF,  1'b1, 48'hFFFFFFFFFFFF},
        {14'd5,     1'b0, 48'h0003FFFFFFFF},
        {14'd6,     1'b1, 48'h0004FFFFFFFF},
        {14'd7,     1'b0, 48'h000000000021}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig_valid = 1'b0;
    logic        trig_ready;
    logic [13:0] trig_evnum = '0;
    logic        hit_valid = 1'b0;
    logic        hit_ready;
    logic        hit_end = 1'b0;
    logic [13:0] hit_word = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [15:0] out_data;

    int          n_chk = 0;
    int          n_fail = 0;
    bit          bp_en = 1'b0;
    int          cyc = 0;
    logic [15:0] exp_q [$];

    always #4 clk = ~clk;

    eb_builder #(.MAX_HITS(MAXH), .BOARD_ID(BID), .GRP_BASE(0)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_valid (trig_valid),
        .trig_ready (trig_ready),
        .trig_evnum (trig_evnum),
        .hit_valid  (hit_valid),
        .hit_ready  (hit_ready),
        .hit_end    (hit_end),
        .hit_word   (hit_word),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_data   (out_data)
    );

    // Periodic downstream stall when backpressure is enabled
    initial forever begin
        @(posedge clk); #1;
        cyc++;
        out_ready = !bp_en || (cyc % 4 != 2);
    end

    // Watchdog: a hung run counts as one failure
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete (actual hung, expected done)");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [15:0] w);
        if (w[15:14] == 2'b01)  return "R2 header0";
        if (w[15:14] == 2'b11)  return "R4 hit";
        if (w[15:14] == 2'b10)  return "R4 group header";
        if (w[15:13] == 3'b001) return "R3 header1";
        return "R5/R7 ender";
    endfunction

    function automatic logic [13:0] hw(input int g, input int k);
        return {4'(k), 2'(g % 4), 8'(g * 16 + k)};
    endfunction

    // Expected stream from the framing and budget rules (R2..R7)
    task automatic build_exp(input logic [13:0] ev, input logic [47:0] pat, output int stored);
        int cnt = 0;
        bit tr  = 1'b0;
        exp_q.delete();
        exp_q.push_back({2'b01, ev});
        exp_q.push_back({3'b001, 5'(BID), 8'h00});
        for (int g = 0; g < 12; g++) begin
            exp_q.push_back({2'b10, 9'h000, 5'(g)});
            for (int k = 0; k < int'(pat[4*g +: 4]); k++) begin
                if (cnt < MAXH) begin
                    exp_q.push_back({2'b11, hw(g, k)});
                    cnt++;
                end else tr = 1'b1;
            end
            if (g % 4 == 3) exp_q.push_back({3'b000, tr, 12'h000});
        end
        stored = cnt;
    endtask

    task automatic send(input bit e, input logic [13:0] w);
        hit_valid = 1'b1;
        hit_end   = e;
        hit_word  = w;
        do @(negedge clk); while (!hit_ready);
        @(posedge clk); #1;
        hit_valid = 1'b0;
        hit_end   = 1'b0;
    endtask

    task automatic drive_event(input logic [13:0] ev, input logic [47:0] pat);
        @(posedge clk); #1;
        trig_valid = 1'b1;
        trig_evnum = ev;
        @(posedge clk); #1;
        trig_valid = 1'b0;
        for (int g = 0; g < 12; g++) begin
            for (int k = 0; k < int'(pat[4*g +: 4]); k++) send(1'b0, hw(g, k));
            send(1'b1, 14'h0);
        end
    endtask

    task automatic consume(output int nh);
        int          idx = 0;
        bit          stall = 1'b0;
        logic [15:0] held = '0;
        nh = 0;
        while (idx < exp_q.size()) begin
            @(negedge clk);
            if (stall) chk(out_valid && out_data == held, "R9 stalled word held", out_data, held);
            stall = out_valid && !out_ready && out_data[15:14] != 2'b11;
            held  = out_data;
            if (out_valid && out_ready) begin
                if (idx == 0) chk(!trig_ready, "R8 busy during event", {15'h0, trig_ready}, 16'h0);
                chk(out_data == exp_q[idx], tag_of(exp_q[idx]), out_data, exp_q[idx]);
                if (out_data[15:14] == 2'b11) nh++;
                idx++;
            end
        end
        @(negedge clk);
        chk(trig_ready, "R8 idle after last ender", {15'h0, trig_ready}, 16'h1);
        chk(!out_valid, "R5 ender is last word", {15'h0, out_valid}, 16'h0);
    endtask

    task automatic run_vec(input logic [62:0] v);
        int stored;
        int nh;
        bp_en = v[48];
        build_exp(v[62:49], v[47:0], stored);
        fork
            drive_event(v[62:49], v[47:0]);
            consume(nh);
        join
        chk(nh == stored, "R6 stored hit count", 16'(nh), 16'(stored));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        chk(trig_ready && !out_valid && !hit_ready, "R1 reset state",
            {13'h0, trig_ready, out_valid, hit_ready}, 16'h0004);
        @(posedge clk); #1;
        rst_n = 1'b1;

        // Table of events
        for (int i = 0; i < NVEC; i++) run_vec(VEC[i]);

        // R10: hit beats offered while idle are not taken
        bp_en = 1'b0;
        @(posedge clk); #1;
        hit_valid = 1'b1;
        hit_word  = 14'h1ABC;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!hit_ready && !out_valid, "R10 no hit accepted while idle",
            {14'h0, hit_ready, out_valid}, 16'h0);
        @(posedge clk); #1;
        hit_valid = 1'b0;

        // R1: reset while waiting in a hit phase
        @(posedge clk); #1;
        trig_valid = 1'b1;
        trig_evnum = 14'd99;
        @(posedge clk); #1;
        trig_valid = 1'b0;
        repeat (6) @(posedge clk);
        #1;
        rst_n = 1'b0;
        @(posedge clk); #1;
        @(negedge clk);
        chk(trig_ready && !out_valid && !hit_ready, "R1 reset mid-event",
            {13'h0, trig_ready, out_valid, hit_ready}, 16'h0004);
        @(posedge clk); #1;
        rst_n = 1'b1;

        // Clean event after the abort
        run_vec(VEC[1]);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule